// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block pulls an 8-bit instruction stream from a byte-wide memory read port and turns it into whole instructions of one, two or three bytes. It decodes the first byte of each instruction for both operation and addressing mode. That decode alone fixes how many further bytes are read. Later bytes never alter the decode. Each finished instruction goes out on a valid/ready stream with these fields:

- the opcode;
- up to two operand bytes;
- a mode code;
- a length;
- a flag that marks an unassigned opcode.

The memory side is a plain request/acknowledge read. The block holds `mem_req` high with a steady `mem_addr` until `mem_ack` returns. The byte on `mem_rdata` is taken in the cycle where both are high. Peripheral registers share the same address space, so there is no separate I/O path. A 16-bit fetch pointer steps once per byte taken and is loaded from `rst_vector` by a synchronous reset.

Back-pressure rules on the output stream:

- While `ins_valid` is high and `ins_ready` is low, every output field stays frozen and no memory read is issued.
- A transfer happens on a clock edge where `ins_valid` and `ins_ready` are both high.
- The next read request rises in the cycle after that transfer.
- `ins_ready` has no effect while `ins_valid` is low.

Top module: `ifs_fetch_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads the fetch pointer from `rst_vector`, drops any partly gathered instruction and leaves `ins_valid` low. After reset `mem_req` is high with `mem_addr` equal to the vector.
- R2: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` holds its value. A byte is consumed only on a cycle with both `mem_req` and `mem_ack` high.
- R3: The fetch pointer advances by one after each consumed byte and wraps from 0xFFFF to 0x0000. Successive reads therefore use consecutive addresses.
- R4: Instruction length on `ins_len` is set by the mode as follows.
  - Length 1: inherent, accumulator A and accumulator B.
  - Length 2: direct, indexed and relative.
  - Length 3: extended.
  - Length 2 for immediate, except opcodes 0x8C, 0x8E and 0xCE, which have length 3.
- R5: `ins_mode` uses these codes: 0 inherent, 1 accumulator A, 2 accumulator B, 3 immediate, 4 direct, 5 indexed, 6 extended, 7 relative. For opcodes below 0x80, the mode follows the high nibble:

  | High nibble | Mode |
  |---|---|
  | 0x0, 0x1, 0x3 | inherent |
  | 0x2 | relative |
  | 0x4 | accumulator A |
  | 0x5 | accumulator B |
  | 0x6 | indexed |
  | 0x7 | extended |

- R6: For opcodes 0x80 to 0xFF, bits 5:4 pick the mode: 0 immediate, 1 direct, 2 indexed, 3 extended. The single exception is 0x8D, which is relative.
- R7: Every opcode is valid except these 59, which raise `ins_illegal`:
  - 00, 02-05, 12-15, 18, 1A, 1C-1F, 21, 38, 3A, 3C, 3D
  - 41, 42, 45, 4B, 4E, 51, 52, 55, 5B, 5E, 61, 62, 65, 6B, 71, 72, 75, 7B
  - 83, 87, 8F, 93, 9D, A3, B3, C3, C7, CC, CD, CF, D3, DC, DD, E3, EC, ED, F3, FC, FD
- R8: An illegal opcode is delivered as a one-byte instruction with mode 0. Fetching resumes at the following address.
- R9: `ins_opcode` carries the first byte. `ins_arg1` carries the second byte and `ins_arg2` the third. Any operand byte the instruction does not have reads as zero.
- R10: While `ins_valid` is high and `ins_ready` is low, all output fields stay unchanged and `mem_req` stays low.
- R11: Instructions leave in stream order with no gaps or repeats. Each instruction starts at the address right after the last byte of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_vector | input | 16 | Fetch address loaded on reset |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address, steady while requested |
| mem_ack | input | 1 | Read data present this cycle |
| mem_rdata | input | 8 | Read data byte |
| ins_valid | output | 1 | Instruction available |
| ins_ready | input | 1 | Consumer accepts instruction |
| ins_opcode | output | 8 | First byte |
| ins_arg1 | output | 8 | Second byte or zero |
| ins_arg2 | output | 8 | Third byte or zero |
| ins_mode | output | 3 | Addressing mode code |
| ins_len | output | 2 | Instruction length in bytes |
| ins_illegal | output | 1 | Unassigned opcode flag |

## Verification
Two situations are hard to reach from the ports: a reset arriving in the middle of a three-byte instruction, and a three-byte instruction that straddles the 0xFFFF to 0x0000 wrap. Directed runs cover both:

- For the mid-instruction reset, the bench forces acknowledges so that only part of an extended instruction has been gathered, then pulses reset with a new vector.
- For the wrap, the bench starts at 0xFFFE on a three-byte immediate.

Beyond these, the bench walks freshly randomised memory images with random acknowledge and ready gaps. Over these runs every opcode appears at an instruction start, and the output is held under back-pressure many times.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2;

  typedef enum logic [2:0] {
    MODE_INH  = 3'd0,
    MODE_ACCA = 3'd1,
    MODE_ACCB = 3'd2,
    MODE_IMM  = 3'd3,
    MODE_DIR  = 3'd4,
    MODE_IDX  = 3'd5,
    MODE_EXT  = 3'd6,
    MODE_REL  = 3'd7
  } mode_e;

  typedef enum logic {
    ST_GATHER  = 1'b0,
    ST_PRESENT = 1'b1
  } state_e;
endpackage

// File: rtl/ifs_opdec.sv
module ifs_opdec
  import ifs_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output logic              legal,
  output mode_e             mode,
  output logic [LEN_W-1:0]  len
);
  logic [15:0] row_ok;
  mode_e       raw_mode;

  // Per high-nibble mask of assigned low nibbles
  always_comb begin
    case (op[7:4])
      4'h0:                row_ok = 16'hFFC2;
      4'h1:                row_ok = 16'h0AC3;
      4'h2:                row_ok = 16'hFFFD;
      4'h3:                row_ok = 16'hCAFF;
      4'h4, 4'h5:          row_ok = 16'hB7D9;
      4'h6, 4'h7:          row_ok = 16'hF7D9;
      4'h8:                row_ok = 16'h7F77;
      4'h9:                row_ok = 16'hDFF7;
      4'hA, 4'hB:          row_ok = 16'hFFF7;
      4'hC:                row_ok = 16'h4F77;
      default:             row_ok = 16'hCFF7;
    endcase
    legal = row_ok[op[3:0]];
  end

  always_comb begin
    if (op[7]) begin
      case (op[5:4])
        2'd0:    raw_mode = MODE_IMM;
        2'd1:    raw_mode = MODE_DIR;
        2'd2:    raw_mode = MODE_IDX;
        default: raw_mode = MODE_EXT;
      endcase
      if (op == 8'h8D) raw_mode = MODE_REL;
    end else begin
      case (op[6:4])
        3'd2:    raw_mode = MODE_REL;
        3'd4:    raw_mode = MODE_ACCA;
        3'd5:    raw_mode = MODE_ACCB;
        3'd6:    raw_mode = MODE_IDX;
        3'd7:    raw_mode = MODE_EXT;
        default: raw_mode = MODE_INH;
      endcase
    end
  end

  always_comb begin
    mode = legal ? raw_mode : MODE_INH;
    case (mode)
      MODE_INH, MODE_ACCA, MODE_ACCB: len = 2'd1;
      MODE_EXT:                       len = 2'd3;
      MODE_IMM:                       len = (op[3:0] == 4'hC || op[3:0] == 4'hE) ? 2'd3 : 2'd2;
      default:                        len = 2'd2;
    endcase
  end
endmodule

// File: rtl/ifs_fetch_ptr.sv
module ifs_fetch_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= load_val;
    else if (advance) ptr_q <= ptr_q + ADDR_W'(1);
  end

  assign ptr = ptr_q;

  // R3: one step per consumed byte, modulo wrap
  a_r3_advance_by_one: assert property (@(posedge clk) disable iff (rst)
    advance |=> ptr == $past(ptr) + ADDR_W'(1));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ptr));
endmodule

// File: rtl/ifs_fetch_seq.sv
module ifs_fetch_seq
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rst_vector,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [BYTE_W-1:0] ins_opcode,
  output logic [BYTE_W-1:0] ins_arg1,
  output logic [BYTE_W-1:0] ins_arg2,
  output logic [2:0]        ins_mode,
  output logic [LEN_W-1:0]  ins_len,
  output logic              ins_illegal
);
  state_e            state_q;
  logic [LEN_W-1:0]  idx_q;
  logic [BYTE_W-1:0] opc_q, arg1_q, arg2_q;
  mode_e             mode_q;
  logic [LEN_W-1:0]  len_q;
  logic              ill_q;

  logic              take;
  logic              dec_legal;
  mode_e             dec_mode;
  logic [LEN_W-1:0]  dec_len;

  assign mem_req = (state_q == ST_GATHER);
  assign take    = mem_req && mem_ack;

  ifs_opdec u_dec (
    .op    (mem_rdata),
    .legal (dec_legal),
    .mode  (dec_mode),
    .len   (dec_len)
  );

  ifs_fetch_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load_val (rst_vector),
    .advance  (take),
    .ptr      (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_GATHER;
      idx_q   <= '0;
      opc_q   <= '0;
      arg1_q  <= '0;
      arg2_q  <= '0;
      mode_q  <= MODE_INH;
      len_q   <= 2'd1;
      ill_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_GATHER: if (take) begin
          case (idx_q)
            2'd0: begin
              opc_q  <= mem_rdata;
              mode_q <= dec_mode;
              len_q  <= dec_len;
              ill_q  <= !dec_legal;
              arg1_q <= '0;
              arg2_q <= '0;
              if (dec_len == 2'd1) state_q <= ST_PRESENT;
              else                 idx_q   <= 2'd1;
            end
            2'd1: begin
              arg1_q <= mem_rdata;
              if (len_q == 2'd2) begin
                state_q <= ST_PRESENT;
                idx_q   <= 2'd0;
              end else begin
                idx_q   <= 2'd2;
              end
            end
            default: begin
              arg2_q  <= mem_rdata;
              state_q <= ST_PRESENT;
              idx_q   <= 2'd0;
            end
          endcase
        end
        default: if (ins_ready) state_q <= ST_GATHER;
      endcase
    end
  end

  assign ins_valid   = (state_q == ST_PRESENT);
  assign ins_opcode  = opc_q;
  assign ins_arg1    = arg1_q;
  assign ins_arg2    = arg2_q;
  assign ins_mode    = mode_q;
  assign ins_len     = len_q;
  assign ins_illegal = ill_q;

  // R1: reset leaves no instruction pending and a read outstanding
  a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ins_valid && mem_req);
  // R2: request and address stay put until acknowledged
  a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R10: frozen output under back-pressure
  a_r10_hold_fields: assert property (@(posedge clk) disable iff (rst)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_opcode) && $stable(ins_arg1)
      && $stable(ins_arg2) && $stable(ins_mode) && $stable(ins_len) && $stable(ins_illegal));
  a_r10_no_read_while_valid: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> !mem_req);
  // R8: illegal codes are single-byte, inherent
  a_r8_illegal_shape: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_illegal |-> ins_len == 2'd1 && ins_mode == 3'd0);
  // R9: missing operand bytes read as zero
  a_r9_arg2_zero: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_len != 2'd3 |-> ins_arg2 == '0);
  // R11: next read starts right after a transfer
  a_r11_resume: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_ready |=> mem_req);
endmodule

// File: tb/ifs_fetch_seq_tb_top.sv
module ifs_fetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] rst_vector = 16'h0000;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        ins_valid;
  logic        ins_ready = 1'b0;
  logic [7:0]  ins_opcode, ins_arg1, ins_arg2;
  logic [2:0]  ins_mode;
  logic [1:0]  ins_len;
  logic        ins_illegal;

  always #4ns clk = ~clk;

  ifs_fetch_seq dut_i (
    .clk(clk), .rst(rst), .rst_vector(rst_vector),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_opcode(ins_opcode),
    .ins_arg1(ins_arg1), .ins_arg2(ins_arg2), .ins_mode(ins_mode),
    .ins_len(ins_len), .ins_illegal(ins_illegal)
  );

  logic [7:0]  mem [0:255];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          taken = 0;
  int          ack_pct = 60;
  int          rdy_pct = 60;
  logic [15:0] bpc, ipc;
  logic        hold_pend = 1'b0;
  logic [7:0]  h_op, h_a1, h_a2;
  logic [2:0]  h_mode;
  logic [1:0]  h_len;
  logic        h_ill;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R7 reference: list of the unassigned codes
  function automatic bit m_illegal(input logic [7:0] op);
    case (op)
      8'h00, 8'h02, 8'h03, 8'h04, 8'h05, 8'h12, 8'h13, 8'h14, 8'h15, 8'h18, 8'h1A,
      8'h1C, 8'h1D, 8'h1E, 8'h1F, 8'h21, 8'h38, 8'h3A, 8'h3C, 8'h3D,
      8'h41, 8'h42, 8'h45, 8'h4B, 8'h4E, 8'h51, 8'h52, 8'h55, 8'h5B, 8'h5E,
      8'h61, 8'h62, 8'h65, 8'h6B, 8'h71, 8'h72, 8'h75, 8'h7B,
      8'h83, 8'h87, 8'h8F, 8'h93, 8'h9D, 8'hA3, 8'hB3,
      8'hC3, 8'hC7, 8'hCC, 8'hCD, 8'hCF, 8'hD3, 8'hDC, 8'hDD,
      8'hE3, 8'hEC, 8'hED, 8'hF3, 8'hFC, 8'hFD: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // R5 / R6 reference
  function automatic logic [2:0] m_mode(input logic [7:0] op);
    if (m_illegal(op)) return 3'd0;
    if (op == 8'h8D) return 3'd7;
    if (op >= 8'h80) return 3'd3 + {1'b0, op[5:4]};
    if (op >= 8'h70) return 3'd6;
    if (op >= 8'h60) return 3'd5;
    if (op >= 8'h50) return 3'd2;
    if (op >= 8'h40) return 3'd1;
    if (op >= 8'h30) return 3'd0;
    if (op >= 8'h20) return 3'd7;
    return 3'd0;
  endfunction

  // R4 reference
  function automatic logic [1:0] m_len(input logic [7:0] op);
    logic [2:0] m;
    m = m_mode(op);
    if (op == 8'h8C || op == 8'h8E || op == 8'hCE) return 2'd3;
    if (m <= 3'd2) return 2'd1;
    if (m == 3'd6) return 2'd3;
    return 2'd2;
  endfunction

  task automatic step();
    @(negedge clk);
    if (ins_valid && hold_pend) begin
      chk(ins_opcode == h_op && ins_arg1 == h_a1 && ins_arg2 == h_a2 &&
          ins_mode == h_mode && ins_len == h_len && ins_illegal == h_ill,
          "R10 held fields", {ins_opcode, ins_arg1, ins_arg2}, {h_op, h_a1, h_a2});
    end
    if (ins_valid) chk(!mem_req, "R10 no read while valid", mem_req, 0);
    if (mem_req) begin
      chk(mem_addr == bpc, "R2/R3 read address", mem_addr, bpc);
      if (($urandom % 100) < ack_pct) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[mem_addr[7:0]];
        bpc       = bpc + 16'd1;
      end else begin
        mem_ack   = 1'b0;
        mem_rdata = 8'($urandom);
      end
    end else begin
      mem_ack = 1'b0;
    end
    if (ins_valid) begin
      if (($urandom % 100) < rdy_pct) begin
        logic [7:0] e_op, e_a1, e_a2;
        logic [1:0] e_len;
        e_op  = mem[ipc[7:0]];
        e_len = m_len(e_op);
        e_a1  = (e_len > 2'd1) ? mem[8'(ipc[7:0] + 8'd1)] : 8'h00;
        e_a2  = (e_len > 2'd2) ? mem[8'(ipc[7:0] + 8'd2)] : 8'h00;
        chk(ins_opcode == e_op, "R11 opcode in order", ins_opcode, e_op);
        chk(ins_len == e_len, "R4 length", ins_len, e_len);
        chk(ins_mode == m_mode(e_op), "R5/R6 mode", ins_mode, m_mode(e_op));
        chk(ins_illegal == m_illegal(e_op), "R7 illegal flag", ins_illegal, m_illegal(e_op));
        chk(ins_arg1 == e_a1 && ins_arg2 == e_a2, "R9 operands",
            {ins_arg1, ins_arg2}, {e_a1, e_a2});
        if (m_illegal(e_op)) chk(ins_len == 2'd1, "R8 illegal is one byte", ins_len, 1);
        ipc = ipc + 16'(e_len);
        taken++;
        hold_pend = 1'b0;
        ins_ready = 1'b1;
      end else begin
        hold_pend = 1'b1;
        h_op = ins_opcode; h_a1 = ins_arg1; h_a2 = ins_arg2;
        h_mode = ins_mode; h_len = ins_len; h_ill = ins_illegal;
        ins_ready = 1'b0;
      end
    end else begin
      hold_pend = 1'b0;
      ins_ready = 1'($urandom % 2);
    end
  endtask

  task automatic do_reset(input logic [15:0] vec);
    @(negedge clk);
    rst = 1'b1; rst_vector = vec; mem_ack = 1'b0; ins_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bpc = vec; ipc = vec; hold_pend = 1'b0;
    chk(!ins_valid, "R1 valid low after reset", ins_valid, 0);
    chk(mem_req, "R1 read pending after reset", mem_req, 1);
    chk(mem_addr == vec, "R1 pointer from vector", mem_addr, vec);
  endtask

  task automatic run_instr(input int n);
    int goal;
    goal = taken + n;
    while (taken < goal) step();
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog R11 actual=%0d expected<=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // R3 wrap: three-byte immediate at 0xFFFE spanning into 0x0000
    fill_random();
    mem[8'hFE] = 8'hCE; mem[8'hFF] = 8'h12; mem[8'h00] = 8'h34;
    ack_pct = 100; rdy_pct = 100;
    do_reset(16'hFFFE);
    run_instr(1);
    @(negedge clk);
    chk(mem_addr == 16'h0001, "R3 wrap to next address", mem_addr, 16'h0001);
    run_instr(20);

    // R8: memory of only unassigned codes
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    ack_pct = 70; rdy_pct = 70;
    do_reset(16'h0200);
    run_instr(40);

    // R1: reset in the middle of an extended instruction
    fill_random();
    mem[8'h40] = 8'hB6; mem[8'h80] = 8'h86;
    ack_pct = 100; rdy_pct = 100;
    do_reset(16'h1240);
    repeat (2) step();
    do_reset(16'h7780);
    run_instr(30);

    // R10: heavy back-pressure
    ack_pct = 90; rdy_pct = 10;
    run_instr(40);

    // random images and gaps
    for (int r = 0; r < 12; r++) begin
      fill_random();
      ack_pct = 30 + ($urandom % 70);
      rdy_pct = 30 + ($urandom % 70);
      do_reset(16'($urandom));
      run_instr(250);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule